// File: doc/BRIEF.md
# Counted Block Input Channel

This block moves a fixed-length run of 36-bit words from a slow input device into main storage while the processor does other work. The processor issues a start command that carries a first storage address and a word count. The channel acknowledges the command. From that cycle on it shows a busy level that the processor can poll.

Each word the device offers is taken over a valid/ready handshake. The channel then writes it to storage through a request/grant handshake at the current channel address. On each grant the address moves up by one and the remaining count moves down by one.

After the count reaches zero the channel holds busy and waits for a disconnect command. The disconnect ends the transfer, drops busy and raises a one-cycle done pulse. A start with a zero count finishes at once.

Top module: `blk_input_channel`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `cmd_ack`, `busy`, `done`, `mem_req` and `dev_ready` are all low.
- R2: A start command (`cmd_op` = 2'b01 with `cmd_valid`) taken while idle raises `cmd_ack` for exactly the next cycle. If the count is nonzero, `busy` goes high in that same cycle.
- R3: A start command presented while `busy` is high gives no `cmd_ack` and leaves the address and count unchanged. The later `mem_addr` values show that nothing changed.
- R4: A start command with `cmd_count` = 0 gives `cmd_ack` and `done` together in the next cycle. `busy` stays low.
- R5: The k-th word accepted from the device (k counting from 0) is written with `mem_addr` = start address + k modulo 2^15, and `mem_wdata` equal to that word.
- R6: Once raised, `mem_req` stays high until a cycle with `mem_gnt` high. `mem_addr` and `mem_wdata` hold steady during that wait.
- R7: `dev_ready` is low whenever `mem_req` is high, whenever the channel is idle, and whenever the remaining count is zero.
- R8: `busy` stays high from the acknowledge until the completing disconnect. A disconnect (`cmd_op` = 2'b10) received while words remain has no effect.
- R9: A disconnect received while busy with zero words remaining gives `done` high for exactly one cycle, the next one. `busy` is low in that cycle.
- R10: A transfer performs exactly `cmd_count` storage writes. No further device word is accepted after the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: 01 start, 10 disconnect, others none |
| cmd_addr | input | 15 | First storage address for a start |
| cmd_count | input | 15 | Number of words for a start |
| cmd_ack | output | 1 | One-cycle acknowledge of an accepted start |
| busy | output | 1 | Channel in operation |
| done | output | 1 | One-cycle completion pulse |
| dev_valid | input | 1 | Device word offered |
| dev_data | input | 36 | Device word |
| dev_ready | output | 1 | Channel can take a device word |
| mem_req | output | 1 | Storage write request |
| mem_addr | output | 15 | Storage write address |
| mem_wdata | output | 36 | Storage write data |
| mem_gnt | input | 1 | Storage write grant |

## Verification
Two situations are hard to reach from the ports. One is a command that lands mid-transfer, such as a second start or an early disconnect. The other is a last word whose grant is held back for several cycles. Neither occurs unless device gaps, grant delays and command timing line up. The stimulus therefore mixes random device gaps and random grant stalls, and injects stray start and disconnect commands during the first transfer cycles. Directed runs cover a zero count and an address range that wraps past the top of storage.

// File: rtl/chan_pkg.sv
package chan_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_START = 2'b01,
    OP_DISC  = 2'b10,
    OP_RSVD  = 2'b11
  } chan_op_e;
endpackage

// File: rtl/chan_ctrl.sv
module chan_ctrl
  import chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_cnt_zero,
  input  logic       cnt_zero,
  output logic       load,
  output logic       busy,
  output logic       ack,
  output logic       done
);
  logic start_ok;
  logic disc_ok;

  assign start_ok = cmd_valid && (cmd_op == OP_START) && !busy;
  assign disc_ok  = cmd_valid && (cmd_op == OP_DISC) && busy && cnt_zero;
  assign load     = start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ack  <= 1'b0;
      done <= 1'b0;
    end else begin
      ack  <= start_ok;
      done <= (start_ok && cmd_cnt_zero) || disc_ok;
      if (start_ok && !cmd_cnt_zero) busy <= 1'b1;
      else if (disc_ok)              busy <= 1'b0;
    end
  end

  // R9
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R3
  start_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && cmd_op == OP_START) |=> !ack);
  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && busy) |=> !ack);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !cnt_zero) |=> busy);
endmodule

// File: rtl/chan_ptrs.sv
module chan_ptrs #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              cnt_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      cnt  <= '0;
    end else if (load) begin
      addr <= ld_addr;
      cnt  <= ld_cnt;
    end else if (step) begin
      addr <= addr + 1'b1;
      cnt  <= cnt - 1'b1;
    end
  end

  assign cnt_zero = (cnt == '0);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    step |-> !cnt_zero);
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/chan_wr_stage.sv
module chan_wr_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cnt_zero,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              step
);
  assign dev_ready = run && !cnt_zero && !mem_req;
  assign step      = mem_req && mem_gnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_wdata <= '0;
    end else if (dev_valid && dev_ready) begin
      mem_req   <= 1'b1;
      mem_wdata <= dev_data;
    end else if (step) begin
      mem_req   <= 1'b0;
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_wdata)));
  // R7
  ready_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !dev_ready);
endmodule

// File: rtl/blk_input_channel.sv
module blk_input_channel
  import chan_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic              cmd_ack,
  output logic              busy,
  output logic              done,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ready,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt
);
  logic load;
  logic step;
  logic cnt_zero;

  chan_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_cnt_zero (cmd_count == '0),
    .cnt_zero     (cnt_zero),
    .load         (load),
    .busy         (busy),
    .ack          (cmd_ack),
    .done         (done)
  );

  chan_ptrs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptrs (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .ld_addr  (cmd_addr),
    .ld_cnt   (cmd_count),
    .step     (step),
    .addr     (mem_addr),
    .cnt_zero (cnt_zero)
  );

  chan_wr_stage #(.DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst       (rst),
    .run       (busy),
    .cnt_zero  (cnt_zero),
    .dev_valid (dev_valid),
    .dev_data  (dev_data),
    .dev_ready (dev_ready),
    .mem_gnt   (mem_gnt),
    .mem_req   (mem_req),
    .mem_wdata (mem_wdata),
    .step      (step)
  );

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> $stable(mem_addr));
  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !dev_ready);
endmodule

// File: tb/blk_input_channel_test.sv
module blk_input_channel_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [14:0] cmd_addr;
  logic [14:0] cmd_count;
  logic        cmd_ack, busy, done, dev_ready, mem_req;
  logic        dev_valid, mem_gnt;
  logic [35:0] dev_data, mem_wdata;
  logic [14:0] mem_addr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  blk_input_channel uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_count(cmd_count), .cmd_ack(cmd_ack),
    .busy(busy), .done(done), .dev_valid(dev_valid), .dev_data(dev_data),
    .dev_ready(dev_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt)
  );

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [35:0] rand_word();
    return {4'($urandom), 32'($urandom)};
  endfunction

  function automatic logic [14:0] exp_addr(logic [14:0] base, int k);
    return 15'(base + 15'(k));
  endfunction

  task automatic send_cmd(logic [1:0] op, logic [14:0] a, logic [14:0] n);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_count = n;
  endtask

  task automatic clear_cmd();
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic run_xfer(logic [14:0] base, int n, bit poke_start, bit poke_disc);
    logic [35:0] exp_w[16];
    int sent = 0;
    int wr = 0;
    int cyc = 0;
    bit hold_pend = 0;
    bit pend_start = 0;
    bit pend_disc = 0;
    logic [35:0] hold_d;
    logic [14:0] hold_a;
    for (int i = 0; i < 16; i++) exp_w[i] = rand_word();
    @(negedge clk);
    send_cmd(2'b01, base, 15'(n));
    @(negedge clk);
    clear_cmd();
    check_eq("R2", "ack after start", cmd_ack, 1);
    check_eq(n == 0 ? "R4" : "R2", "busy after start", busy, n != 0);
    check_eq("R4", "done after start", done, n == 0);
    if (n == 0) begin
      @(negedge clk);
      check_eq("R4", "ack drops", cmd_ack, 0);
      check_eq("R4", "done drops", done, 0);
      check_eq("R4", "busy stays low", busy, 0);
      return;
    end
    while (wr < n) begin
      if (pend_start) begin
        check_eq("R3", "no ack for start while busy", cmd_ack, 0);
        pend_start = 0;
      end
      if (pend_disc) begin
        check_eq("R8", "early disconnect no done", done, 0);
        check_eq("R8", "early disconnect keeps busy", busy, 1);
        pend_disc = 0;
      end
      clear_cmd();
      if (hold_pend) begin
        check_eq("R6", "req held", mem_req, 1);
        check_eq("R6", "addr stable", mem_addr, hold_a);
        check_eq("R6", "data stable", mem_wdata, hold_d);
      end
      check_eq("R8", "busy during transfer", busy, 1);
      if (mem_req) check_eq("R7", "ready low while req", dev_ready, 0);
      mem_gnt = mem_req && ($urandom % 3 != 0);
      hold_pend = mem_req && !mem_gnt;
      hold_a = mem_addr;
      hold_d = mem_wdata;
      if (mem_gnt) begin
        check_eq("R5", "write address", mem_addr, exp_addr(base, wr));
        check_eq("R5", "write data", mem_wdata, exp_w[wr]);
        wr++;
      end
      dev_valid = (sent < n) && ($urandom % 4 != 0);
      dev_data = dev_valid ? exp_w[sent] : rand_word();
      if (dev_valid && dev_ready) sent++;
      if (poke_start && cyc == 0) begin
        send_cmd(2'b01, 15'(base + 15'd100), 15'd5);
        pend_start = 1;
      end
      if (poke_disc && cyc == 1) begin
        send_cmd(2'b10, 15'd0, 15'd0);
        pend_disc = 1;
      end
      cyc++;
      @(negedge clk);
    end
    mem_gnt = 1'b0;
    if (pend_start) check_eq("R3", "no ack for start while busy", cmd_ack, 0);
    if (pend_disc) check_eq("R8", "early disconnect keeps busy", busy, 1);
    clear_cmd();
    dev_valid = 1'b1;
    dev_data = rand_word();
    for (int i = 0; i < 3; i++) begin
      check_eq("R10", "no ready after last word", dev_ready, 0);
      check_eq("R10", "no write after last word", mem_req, 0);
      check_eq("R8", "busy until disconnect", busy, 1);
      @(negedge clk);
    end
    dev_valid = 1'b0;
    check_eq("R10", "word count sent", 64'(sent), 64'(n));
    send_cmd(2'b10, 15'd0, 15'd0);
    @(negedge clk);
    clear_cmd();
    check_eq("R9", "done on disconnect", done, 1);
    check_eq("R9", "busy low with done", busy, 0);
    @(negedge clk);
    check_eq("R9", "done one cycle", done, 0);
    check_eq("R7", "ready low when idle", dev_ready, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_count = 0;
    dev_valid = 0; dev_data = 0; mem_gnt = 0;
    repeat (3) @(negedge clk);
    check_eq("R1", "ack in reset", cmd_ack, 0);
    check_eq("R1", "busy in reset", busy, 0);
    check_eq("R1", "done in reset", done, 0);
    check_eq("R1", "req in reset", mem_req, 0);
    check_eq("R1", "ready in reset", dev_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1", "busy after reset", busy, 0);
    check_eq("R1", "req after reset", mem_req, 0);

    run_xfer(15'h0014, 2, 0, 0);
    run_xfer(15'h0100, 0, 0, 0);
    run_xfer(15'h7FFE, 4, 0, 0);
    run_xfer(15'h0200, 6, 1, 1);
    run_xfer(15'h0300, 1, 1, 1);
    for (int t = 0; t < 30; t++)
      run_xfer(15'($urandom), int'($urandom % 16), $urandom % 2 == 1, $urandom % 2 == 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule